// File: doc/BRIEF.md
# Programmable Pin Glitch Filter

This block cleans up one asynchronous pin input before it reaches pin-status and interrupt detection logic. The raw pin first passes through a synchroniser chain. A filter then decides when the clean output may follow the synchronised level. The filter measures time in ticks of a slow real-time enable strobe, which pulses once per period of a 32.768 kHz clock. The strobe is generated outside this block.

Software supplies four configuration fields as plain input ports:
- a 4-bit timeout count;
- a fine/coarse unit bit and a large-range bit, which together pick a base period of 2, 8, 512 or 2048 ticks;
- a 2-bit mode.

The mode selects one of four behaviours. In bypass, the output follows the synchronised pin. In symmetric mode, every change must be stable for the full window. The two asymmetric modes let a change toward one chosen level pass at once, while the opposite change is still filtered. Edge-sensitive interrupt pins normally use symmetric mode. Level-high pins use the mode that passes falls at once. Level-low pins use the mode that passes rises at once.

Top module: `pin_deglitch`

## Requirements
- R1: The raw pin passes through a two-flop synchroniser. No change on `pin_raw` can reach the filter before two rising clock edges have passed.
- R2: The base period is set by {`cfg_large`,`cfg_unit`}: 00 gives 2 ticks, 01 gives 8, 10 gives 512 and 11 gives 2048. With a count of 1 in symmetric mode, a rise that was applied before edge 1 appears on `level_out` after edge 2+base, with `tick_en` high every cycle.
- R3: The filter window is count × base ticks. A count of 0, with filtering active, acts as a count of 1.
- R4: In symmetric mode (`cfg_mode`=1), `level_out` changes only after the synchronised level has differed from it for a full window. Any return to the output level restarts the window from zero.
- R5: In pass-low mode (`cfg_mode`=2), a fall reaches `level_out` one edge after it leaves the synchroniser, which is three edges after the pin changes. A rise is filtered as in R4.
- R6: In pass-high mode (`cfg_mode`=3), a rise reaches `level_out` three edges after the pin changes. A fall is filtered as in R4.
- R7: In bypass mode (`cfg_mode`=0), `level_out` equals `pin_raw` as it was three rising edges earlier.
- R8: The window timer advances only on cycles where `tick_en` is high. With `tick_en` low, a filtered output never changes.
- R9: Any cycle in which the configuration differs from its value in the previous cycle clears the window timer and holds `level_out` for that cycle. This holds even if the timer would have expired in that same cycle.
- R10: While `rst_n` is low, the synchroniser, the timer, the stored configuration and `level_out` are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pin_raw | input | 1 | Asynchronous pin level |
| tick_en | input | 1 | One-cycle strobe per real-time clock tick |
| cfg_count | input | 4 | Window length in base periods (0 treated as 1) |
| cfg_unit | input | 1 | Base period select, low bit |
| cfg_large | input | 1 | Base period select, high bit |
| cfg_mode | input | 2 | 0 bypass, 1 symmetric, 2 pass-low, 3 pass-high |
| level_out | output | 1 | Filtered pin level |

## Verification
A configuration write and the expiry of the window timer can land on the same clock edge. The bench provokes this by running a short window with `tick_en` high every cycle and changing `cfg_count` in the cycle whose tick would complete the window. The design must give priority to the configuration change: `level_out` must stay at its old level on that edge, and the window must then restart in full under the new setting. Random segments also change the configuration at arbitrary moments against a cycle-level model, so this collision is met at many timer values.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS    = 2'd0,
        MODE_SYMMETRIC = 2'd1,
        MODE_PASS_LOW  = 2'd2,
        MODE_PASS_HIGH = 2'd3
    } filt_mode_e;

endpackage

// File: rtl/pdg_sync.sv
module pdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

    generate
        if (STAGES > 1) begin : g_chk
            // R1: the last stage carries what the stage before it held one edge earlier
            p_sync_chain_r1: assert property (@(posedge clk) disable iff (!rst_n)
                q == $past(chain_q[STAGES-2]));
        end
    endgenerate
endmodule

// File: rtl/pdg_span.sv
module pdg_span #(
    parameter int CNT_W    = 4,
    parameter int SH_FINE  = 1,
    parameter int SH_MED   = 3,
    parameter int SH_LARGE = 9,
    parameter int SH_HUGE  = 11,
    localparam int LIM_W   = CNT_W + SH_HUGE
) (
    input  logic [CNT_W-1:0] count,
    input  logic             unit_sel,
    input  logic             large_sel,
    output logic [LIM_W-1:0] limit
);
    logic [CNT_W-1:0] eff_count;
    logic [LIM_W-1:0] wide_count;

    always_comb begin
        eff_count  = (count == '0) ? CNT_W'(1) : count;
        wide_count = LIM_W'(eff_count);
        unique case ({large_sel, unit_sel})
            2'b00:   limit = wide_count << SH_FINE;
            2'b01:   limit = wide_count << SH_MED;
            2'b10:   limit = wide_count << SH_LARGE;
            default: limit = wide_count << SH_HUGE;
        endcase
    end

    always_comb begin
        // R3: a window is never shorter than one fine base period
        a_limit_nonzero_r3: assert (limit >= LIM_W'(1 << SH_FINE));
    end
endmodule

// File: rtl/pdg_filter.sv
module pdg_filter
    import pdg_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LIM_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_in,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_unit,
    input  logic             cfg_large,
    input  filt_mode_e       cfg_mode,
    input  logic [LIM_W-1:0] limit,
    output logic             level
);
    localparam int CFG_W = CNT_W + 4;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [LIM_W-1:0] cnt;
        logic             out;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic [CFG_W-1:0] cfg_now;
    logic             cfg_chg;
    logic             fast_path;

    always_comb begin
        cfg_now   = {cfg_count, cfg_unit, cfg_large, cfg_mode};
        cfg_chg   = (cfg_now != st_q.cfg);
        fast_path = ((cfg_mode == MODE_PASS_LOW)  && !s_in) ||
                    ((cfg_mode == MODE_PASS_HIGH) &&  s_in);
        st_d      = st_q;
        st_d.cfg  = cfg_now;
        if (cfg_chg) begin
            st_d.cnt = '0;
        end else if (cfg_mode == MODE_BYPASS) begin
            st_d.out = s_in;
            st_d.cnt = '0;
        end else if (s_in == st_q.out) begin
            st_d.cnt = '0;
        end else if (fast_path) begin
            st_d.out = s_in;
            st_d.cnt = '0;
        end else if (tick_en) begin
            if (st_q.cnt == limit - LIM_W'(1)) begin
                st_d.out = s_in;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + LIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.out;

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> (st_q.cnt < limit));
    p_bounce_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != MODE_BYPASS && s_in == st_q.out) |=> (st_q.cnt == '0));
    p_fast_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chg && cfg_mode == MODE_PASS_LOW && !s_in) |=> !level);
    p_fast_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chg && cfg_mode == MODE_PASS_HIGH && s_in) |=> level);
    p_bypass_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chg && cfg_mode == MODE_BYPASS) |=> (level == $past(s_in)));
    p_tick_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chg && cfg_mode == MODE_SYMMETRIC && !tick_en) |=> $stable(level));
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> ($stable(level) && st_q.cnt == '0));
endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch
    import pdg_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SH_FINE     = 1,
    parameter int SH_MED      = 3,
    parameter int SH_LARGE    = 9,
    parameter int SH_HUGE     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_unit,
    input  logic             cfg_large,
    input  logic [1:0]       cfg_mode,
    output logic             level_out
);
    localparam int LIM_W = CNT_W + SH_HUGE;

    logic             pin_sync;
    logic [LIM_W-1:0] win_limit;
    filt_mode_e       mode_sel;

    assign mode_sel = filt_mode_e'(cfg_mode);

    pdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_sync)
    );

    pdg_span #(
        .CNT_W    (CNT_W),
        .SH_FINE  (SH_FINE),
        .SH_MED   (SH_MED),
        .SH_LARGE (SH_LARGE),
        .SH_HUGE  (SH_HUGE)
    ) u_span (
        .count     (cfg_count),
        .unit_sel  (cfg_unit),
        .large_sel (cfg_large),
        .limit     (win_limit)
    );

    pdg_filter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_in      (pin_sync),
        .tick_en   (tick_en),
        .cfg_count (cfg_count),
        .cfg_unit  (cfg_unit),
        .cfg_large (cfg_large),
        .cfg_mode  (mode_sel),
        .limit     (win_limit),
        .level     (level_out)
    );
endmodule

// File: tb/pin_deglitch_test.sv
`timescale 1ns/1ps
module pin_deglitch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] cfg_count = '0;
    logic       cfg_unit = 1'b0;
    logic       cfg_large = 1'b0;
    logic [1:0] cfg_mode = '0;
    logic       level_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic m_s1 = 0, m_s2 = 0, m_out = 0;
    int   m_cnt = 0;
    int   m_cfg = 0;

    always #10 clk = ~clk;

    pin_deglitch uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .tick_en(tick_en),
        .cfg_count(cfg_count), .cfg_unit(cfg_unit), .cfg_large(cfg_large),
        .cfg_mode(cfg_mode), .level_out(level_out)
    );

    function automatic int base_ticks(input logic lg, input logic un);
        case ({lg, un})
            2'b00:   return 2;
            2'b01:   return 8;
            2'b10:   return 512;
            default: return 2048;
        endcase
    endfunction

    function automatic int window(input logic [3:0] c, input logic lg, input logic un);
        return ((c == 0) ? 1 : int'(c)) * base_ticks(lg, un);
    endfunction

    task automatic model_step(input logic p, input logic t);
        int  cfg_enc;
        bit  chg;
        logic s;
        cfg_enc = {cfg_count, cfg_unit, cfg_large, cfg_mode};
        chg = (cfg_enc != m_cfg);
        m_cfg = cfg_enc;
        s = m_s2;
        if (chg) m_cnt = 0;
        else if (cfg_mode == 2'd0) begin m_out = s; m_cnt = 0; end
        else if (s == m_out) m_cnt = 0;
        else if ((cfg_mode == 2'd2 && !s) || (cfg_mode == 2'd3 && s)) begin
            m_out = s; m_cnt = 0;
        end else if (t) begin
            if (m_cnt + 1 >= window(cfg_count, cfg_large, cfg_unit)) begin
                m_out = s; m_cnt = 0;
            end else m_cnt = m_cnt + 1;
        end
        m_s2 = m_s1;
        m_s1 = p;
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // called at a negedge; drives inputs, steps model past the next edge, compares
    task automatic cyc(input logic p, input logic t, input string tag);
        pin_raw = p;
        tick_en = t;
        @(posedge clk);
        #1 model_step(p, t);
        @(negedge clk);
        check(level_out, m_out, tag);
    endtask

    task automatic set_cfg(input logic [3:0] c, input logic un, input logic lg, input logic [1:0] md);
        cfg_count = c; cfg_unit = un; cfg_large = lg; cfg_mode = md;
    endtask

    // drive pin to level p, count edges until output reaches it
    task automatic measure(input logic p, input int limit_n, input string tag, output int n);
        n = 0;
        do begin
            cyc(p, 1'b1, tag);
            n++;
        end while (level_out !== p && n < limit_n);
    endtask

    // settle output to level v through bypass mode
    task automatic settle(input logic v);
        set_cfg(4'd0, 1'b0, 1'b0, 2'd0);
        for (int i = 0; i < 6; i++) cyc(v, 1'b0, "R7 settle");
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(level_out, 1'b0, "R10 reset level");
        rst_n = 1'b1;

        // R7 / R1: bypass latency three edges
        settle(1'b0);
        cyc(1'b1, 1'b0, "R1 edge1");
        check(level_out, 1'b0, "R1 not after one edge");
        cyc(1'b1, 1'b0, "R1 edge2");
        check(level_out, 1'b0, "R1 not after two edges");
        cyc(1'b1, 1'b0, "R7 edge3");
        check(level_out, 1'b1, "R7 follows after three edges");

        // R2: each base period with count 1
        for (int r = 0; r < 4; r++) begin
            logic lg, un;
            lg = r[1]; un = r[0];
            settle(1'b0);
            set_cfg(4'd1, un, lg, 2'd1);
            for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, "R2 prep");
            measure(1'b1, 5000, "R2 range", n);
            check_int(n, 2 + base_ticks(lg, un), "R2 base period");
        end

        // R3: count zero equals one period, count 15 full window
        settle(1'b0);
        set_cfg(4'd0, 1'b0, 1'b0, 2'd1);
        cyc(1'b0, 1'b1, "R3 prep");
        measure(1'b1, 100, "R3 zero", n);
        check_int(n, 4, "R3 count zero acts as one");
        set_cfg(4'd15, 1'b0, 1'b0, 2'd1);
        cyc(1'b1, 1'b1, "R3 prep");
        measure(1'b0, 100, "R3 fifteen", n);
        check_int(n, 32, "R3 count fifteen");

        // R4: bounce restarts window (window 6 ticks)
        settle(1'b0);
        set_cfg(4'd3, 1'b0, 1'b0, 2'd1);
        cyc(1'b0, 1'b1, "R4 prep");
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, "R4 before bounce");
        cyc(1'b0, 1'b1, "R4 bounce");
        check(level_out, 1'b0, "R4 no early flip");
        measure(1'b1, 100, "R4 after bounce", n);
        check_int(n, 8, "R4 window restarts after bounce");

        // R5: pass-low
        settle(1'b1);
        set_cfg(4'd2, 1'b0, 1'b0, 2'd2);
        cyc(1'b1, 1'b1, "R5 prep");
        measure(1'b0, 100, "R5 fall", n);
        check_int(n, 3, "R5 fall passes at once");
        measure(1'b1, 100, "R5 rise", n);
        check_int(n, 6, "R5 rise filtered");

        // R6: pass-high
        settle(1'b0);
        set_cfg(4'd2, 1'b0, 1'b0, 2'd3);
        cyc(1'b0, 1'b1, "R6 prep");
        measure(1'b1, 100, "R6 rise", n);
        check_int(n, 3, "R6 rise passes at once");
        measure(1'b0, 100, "R6 fall", n);
        check_int(n, 6, "R6 fall filtered");

        // R8: no tick, no change
        settle(1'b0);
        set_cfg(4'd1, 1'b0, 1'b0, 2'd1);
        cyc(1'b0, 1'b0, "R8 prep");
        for (int i = 0; i < 50; i++) cyc(1'b1, 1'b0, "R8 no tick");
        check(level_out, 1'b0, "R8 held without ticks");
        cyc(1'b1, 1'b1, "R8 tick1");
        cyc(1'b1, 1'b1, "R8 tick2");
        check(level_out, 1'b1, "R8 flips after two ticks");

        // R9: config change on the expiry edge
        settle(1'b0);
        set_cfg(4'd1, 1'b0, 1'b0, 2'd1);
        cyc(1'b0, 1'b1, "R9 prep");
        cyc(1'b1, 1'b1, "R9 e1");
        cyc(1'b1, 1'b1, "R9 e2");
        cyc(1'b1, 1'b1, "R9 e3");
        cfg_count = 4'd2;
        cyc(1'b1, 1'b1, "R9 collide");
        check(level_out, 1'b0, "R9 held on config change");
        measure(1'b1, 100, "R9 restart", n);
        check_int(n, 4, "R9 full new window");

        // random segments
        for (int seg = 0; seg < 40; seg++) begin
            int tick_pct, tog_pct;
            set_cfg(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                    ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3)));
            tick_pct = $urandom_range(10, 100);
            tog_pct  = $urandom_range(1, 20);
            for (int i = 0; i < 1500; i++) begin
                logic p, t;
                p = ($urandom_range(0, 99) < tog_pct) ? ~pin_raw : pin_raw;
                t = ($urandom_range(0, 99) < tick_pct);
                if ($urandom_range(0, 999) == 0) cfg_count = 4'($urandom_range(0, 15));
                cyc(p, t, "R4 R9 random model");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule